// File: doc/BRIEF.md
# Dual-Mode Alarm Timer

This block is a real-time timer built around a wide up counter that moves by one on each cycle where a tick enable is high. The tick enable normally comes from a slow reference, 32768 Hz by default. A compare register holds an alarm value. When a tick arrives while the counter equals that value, the block raises a one-cycle alarm pulse and sets an alarm flag that stays set. Software can load the counter, change the alarm value and pick the mode through simple write strobes.

There are two modes. In free-running mode the counter is never cleared. It wraps from all-ones to zero, and software moves the alarm forward after each alarm using modulo addition. Because the counter and the alarm wrap the same way, the next match is still found after a wrap. In auto-reset mode the block clears the counter to zero on each alarm. The compare register then holds a fixed interval that is written once and reused for every later alarm.

A 16-bit count of counter wraps extends the timebase to 48 bits. A read strobe captures the counter and the wrap count on the same edge, so software always sees a matching pair of halves.

Top module: `rtc_alarm_timer`

## Requirements
- R1: A synchronous active-high `rst` clears the counter, the wrap count, the alarm pulse, both sticky flags and the snapshot. It also sets the alarm register to all ones and the mode to free-running (mode bit 0).
- R2: The counter changes only on cycles where `tick_en` is high (or on a load). On every other cycle it holds its value.
- R3: In free-running mode (mode bit 0) the counter steps from all ones to zero and keeps counting without a pause or a lost tick.
- R4: An alarm event happens on a tick cycle in which the counter equals the alarm register. In the following cycle `alarm_pulse_o` is high for exactly one cycle and `alarm_flag_o` is set. In free-running mode the counter goes on to alarm+1.
- R5: In auto-reset mode (mode bit 1) an alarm event loads zero into the counter, so the count runs 0..N and each alarm comes N+1 ticks after the last. This repeats with no further write.
- R6: An alarm value written with modulo 2^32 arithmetic past the wrap point matches after the counter wraps.
- R7: `alarm_flag_o` stays set until a cycle with `alarm_clr` high. If an alarm event and a clear fall in the same cycle, the flag is set.
- R8: Each step of the counter from all ones to zero adds one to `ovf_count_o` (modulo 2^16) and sets `ovf_flag_o`, which stays set until `ovf_clr`. A clear to zero caused by an auto-reset alarm is not an overflow.
- R9: Writing the alarm value or the mode does not change the counter. The new setting is used from the next tick.
- R10: `time_we` loads `time_wdata` into the counter. The load wins over a tick in the same cycle, and that cycle produces neither an alarm event nor an overflow.
- R11: `rd_req` captures the counter and the wrap count from the same cycle into `rd_lo_o`/`rd_hi_o`. The captured values appear on the next cycle and are held until the next `rd_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable, one cycle per timer tick |
| alarm_we | input | 1 | Write strobe for the alarm register |
| alarm_wdata | input | 32 | New alarm value or interval |
| mode_we | input | 1 | Write strobe for the mode bit |
| mode_wdata | input | 1 | 0 free-running, 1 auto-reset |
| time_we | input | 1 | Counter load strobe |
| time_wdata | input | 32 | Counter load value |
| alarm_clr | input | 1 | Clears the alarm flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| rd_req | input | 1 | Captures the 48-bit time snapshot |
| count_o | output | 32 | Live counter value |
| ovf_count_o | output | 16 | Live wrap count |
| alarm_pulse_o | output | 1 | One-cycle alarm pulse |
| alarm_flag_o | output | 1 | Sticky alarm flag |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| rd_lo_o | output | 32 | Snapshot, low half (counter) |
| rd_hi_o | output | 16 | Snapshot, high half (wrap count) |

## Verification
The assertions assume that every control input is a clean single-cycle strobe sampled at the rising edge. They also assume that `time_we` fully decides the counter on its cycle, so no tick step is checked against a load. The stimulus keeps to this by changing inputs only on falling edges and dropping every strobe after one cycle. It takes the counter into the wrap region with loads instead of long runs of ticks. It inserts idle cycles between ticks, so the hold behaviour is exercised along with counting.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  typedef enum logic {
    MODE_FREE = 1'b0,
    MODE_AUTO = 1'b1
  } rtc_mode_e;
endpackage

// File: rtl/rtc_cfg_regs.sv
module rtc_cfg_regs
  import rtc_alarm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alarm_we,
  input  logic [CNT_W-1:0] alarm_wdata,
  input  logic             mode_we,
  input  logic             mode_wdata,
  output logic [CNT_W-1:0] alarm_q,
  output rtc_mode_e        mode_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_q <= {CNT_W{1'b1}};
      mode_q  <= MODE_FREE;
    end else begin
      if (alarm_we) alarm_q <= alarm_wdata;
      if (mode_we)  mode_q  <= rtc_mode_e'(mode_wdata);
    end
  end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int CNT_W = 32,
  parameter int OVF_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clear_i,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic [OVF_W-1:0] ovf_cnt_q,
  output logic             ovf_flag_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic step;
  logic wrap;

  assign step = tick_en && !load_en;
  assign wrap = step && !clear_i && (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_en) begin
      cnt_q <= load_val;
    end else if (step) begin
      if (clear_i) cnt_q <= '0;
      else         cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_cnt_q  <= '0;
      ovf_flag_q <= 1'b0;
    end else begin
      if (wrap) ovf_cnt_q <= ovf_cnt_q + 1'b1;
      if (wrap)         ovf_flag_q <= 1'b1;
      else if (ovf_clr) ovf_flag_q <= 1'b0;
    end
  end

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !load_en) |=> $stable(cnt_q));

  // R5
  auto_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (step && clear_i) |=> (cnt_q == '0));

  // R8
  wrap_counts_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (ovf_flag_q && (cnt_q == '0)));

  // R10
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/rtc_match.sv
module rtc_match #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             load_en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] alarm,
  input  logic             alarm_clr,
  output logic             hit,
  output logic             pulse_q,
  output logic             flag_q
);
  assign hit = tick_en && !load_en && (cnt == alarm);

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      pulse_q <= hit;
      if (hit)            flag_q <= 1'b1;
      else if (alarm_clr) flag_q <= 1'b0;
    end
  end

  // R4
  pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> flag_q);

  // R4
  event_to_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> pulse_q);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !alarm_clr) |=> flag_q);
endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot #(
  parameter int CNT_W = 32,
  parameter int OVF_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_req,
  input  logic [CNT_W-1:0] cnt,
  input  logic [OVF_W-1:0] ovf_cnt,
  output logic [CNT_W-1:0] lo_q,
  output logic [OVF_W-1:0] hi_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (rd_req) begin
      lo_q <= cnt;
      hi_q <= ovf_cnt;
    end
  end

  // R11
  snap_pair_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> ((lo_q == $past(cnt)) && (hi_q == $past(ovf_cnt))));

  // R11
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/rtc_alarm_timer.sv
module rtc_alarm_timer
  import rtc_alarm_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int OVF_W   = 16,
  parameter int TICK_HZ = 32768
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             alarm_we,
  input  logic [CNT_W-1:0] alarm_wdata,
  input  logic             mode_we,
  input  logic             mode_wdata,
  input  logic             time_we,
  input  logic [CNT_W-1:0] time_wdata,
  input  logic             alarm_clr,
  input  logic             ovf_clr,
  input  logic             rd_req,
  output logic [CNT_W-1:0] count_o,
  output logic [OVF_W-1:0] ovf_count_o,
  output logic             alarm_pulse_o,
  output logic             alarm_flag_o,
  output logic             ovf_flag_o,
  output logic [CNT_W-1:0] rd_lo_o,
  output logic [OVF_W-1:0] rd_hi_o
);
  localparam int TIME_W = CNT_W + OVF_W;

  initial begin
    if (TICK_HZ <= 0) $error("tick rate must be positive");
    if (TIME_W < CNT_W) $error("bad timebase width");
  end

  logic [CNT_W-1:0] alarm_q;
  rtc_mode_e        mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OVF_W-1:0] ovf_cnt_q;
  logic             hit;
  logic             clear_on_hit;

  rtc_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst(rst),
    .alarm_we(alarm_we), .alarm_wdata(alarm_wdata),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .alarm_q(alarm_q), .mode_q(mode_q)
  );

  rtc_match #(.CNT_W(CNT_W)) u_match (
    .clk(clk), .rst(rst), .tick_en(tick_en), .load_en(time_we),
    .cnt(cnt_q), .alarm(alarm_q), .alarm_clr(alarm_clr),
    .hit(hit), .pulse_q(alarm_pulse_o), .flag_q(alarm_flag_o)
  );

  assign clear_on_hit = hit && (mode_q == MODE_AUTO);

  rtc_counter #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_counter (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .load_en(time_we), .load_val(time_wdata),
    .clear_i(clear_on_hit), .ovf_clr(ovf_clr),
    .cnt_q(cnt_q), .ovf_cnt_q(ovf_cnt_q), .ovf_flag_q(ovf_flag_o)
  );

  rtc_snapshot #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_snap (
    .clk(clk), .rst(rst), .rd_req(rd_req),
    .cnt(cnt_q), .ovf_cnt(ovf_cnt_q),
    .lo_q(rd_lo_o), .hi_q(rd_hi_o)
  );

  assign count_o     = cnt_q;
  assign ovf_count_o = ovf_cnt_q;

  // R3
  free_runs_on_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !time_we && (mode_q == MODE_FREE)) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R9
  cfg_keeps_count_chk: assert property (@(posedge clk) disable iff (rst)
    ((alarm_we || mode_we) && !tick_en && !time_we) |=> $stable(cnt_q));
endmodule

// File: tb/rtc_alarm_timer_bench.sv
module rtc_alarm_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 0, alarm_we = 0, mode_we = 0, mode_wdata = 0, time_we = 0;
  logic        alarm_clr = 0, ovf_clr = 0, rd_req = 0;
  logic [31:0] alarm_wdata = '0, time_wdata = '0;
  logic [31:0] count_o, rd_lo_o;
  logic [15:0] ovf_count_o, rd_hi_o;
  logic        alarm_pulse_o, alarm_flag_o, ovf_flag_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  rtc_alarm_timer u_rtc_alarm_timer (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .alarm_we(alarm_we), .alarm_wdata(alarm_wdata),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .time_we(time_we), .time_wdata(time_wdata),
    .alarm_clr(alarm_clr), .ovf_clr(ovf_clr), .rd_req(rd_req),
    .count_o(count_o), .ovf_count_o(ovf_count_o),
    .alarm_pulse_o(alarm_pulse_o), .alarm_flag_o(alarm_flag_o),
    .ovf_flag_o(ovf_flag_o), .rd_lo_o(rd_lo_o), .rd_hi_o(rd_hi_o)
  );

  typedef struct packed {
    logic        mode;
    logic [31:0] alarm;
    logic [31:0] preset;
    logic [7:0]  ticks;
    logic [31:0] exp_cnt;
    logic        exp_flag;
    logic [15:0] exp_ovf;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'd10,         32'd0,          8'd5,  32'd5,  1'b0, 16'd0},
    '{1'b0, 32'd10,         32'd0,          8'd11, 32'd11, 1'b1, 16'd0},
    '{1'b0, 32'd10,         32'd0,          8'd10, 32'd10, 1'b0, 16'd0},
    '{1'b1, 32'd4,          32'd0,          8'd5,  32'd0,  1'b1, 16'd0},
    '{1'b1, 32'd4,          32'd0,          8'd7,  32'd2,  1'b1, 16'd0},
    '{1'b0, 32'd1,          32'hFFFFFFFE,   8'd3,  32'd1,  1'b0, 16'd1},
    '{1'b0, 32'd0,          32'hFFFFFFFE,   8'd3,  32'd1,  1'b1, 16'd1},
    '{1'b1, 32'd0,          32'd0,          8'd3,  32'd0,  1'b1, 16'd0},
    '{1'b1, 32'd5,          32'd8,          8'd4,  32'd12, 1'b0, 16'd0},
    '{1'b1, 32'hFFFFFFFF,   32'hFFFFFFFE,   8'd2,  32'd0,  1'b1, 16'd0},
    '{1'b0, 32'hFFFFFFFF,   32'hFFFFFFFE,   8'd2,  32'd0,  1'b1, 16'd1}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic tick();
    tick_en = 1; @(negedge clk); tick_en = 0;
  endtask

  task automatic do_reset();
    rst = 1; @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic wr_alarm(input logic [31:0] v);
    alarm_we = 1; alarm_wdata = v; @(negedge clk); alarm_we = 0;
  endtask

  task automatic wr_mode(input logic m);
    mode_we = 1; mode_wdata = m; @(negedge clk); mode_we = 0;
  endtask

  task automatic wr_time(input logic [31:0] v);
    time_we = 1; time_wdata = v; @(negedge clk); time_we = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int pulses;
    @(negedge clk);
    do_reset();

    // R1 reset state
    check("R1 count", count_o, 0);
    check("R1 ovf", ovf_count_o, 0);
    check("R1 flags", {alarm_pulse_o, alarm_flag_o, ovf_flag_o}, 0);
    check("R1 snapshot", {rd_hi_o, rd_lo_o}, 0);

    // table walk: R2 R3 R4 R5 R6 R8 with idle gaps between ticks
    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr_mode(VECS[i].mode);
      wr_alarm(VECS[i].alarm);
      wr_time(VECS[i].preset);
      for (int t = 0; t < int'(VECS[i].ticks); t++) begin
        tick();
        idle();
      end
      check($sformatf("R2/R3/R5 count vec%0d", i), count_o, VECS[i].exp_cnt);
      check($sformatf("R4/R6 flag vec%0d", i), alarm_flag_o, VECS[i].exp_flag);
      check($sformatf("R8 ovf vec%0d", i), ovf_count_o, VECS[i].exp_ovf);
    end

    // R1: reset values of alarm (all ones) and mode (free)
    do_reset();
    wr_time(32'hFFFFFFFF);
    tick();
    check("R1 alarm reset all ones", {alarm_pulse_o, alarm_flag_o}, 2'b11);
    check("R1 mode reset free", {ovf_count_o, count_o}, {16'd1, 32'd0});

    // R4 + R5: one-cycle pulses, interval reused
    do_reset();
    wr_mode(1'b1);
    wr_alarm(32'd2);
    pulses = 0;
    for (int t = 0; t < 9; t++) begin
      tick_en = 1; @(negedge clk);
      if (alarm_pulse_o) pulses++;
    end
    tick_en = 0;
    check("R5 pulses in 9 ticks", pulses, 3);
    check("R5 count after 3 periods", count_o, 0);
    idle();
    check("R4 pulse one cycle", alarm_pulse_o, 0);

    // R7 sticky flag and clear
    idle(); idle();
    check("R7 flag held", alarm_flag_o, 1);
    alarm_clr = 1; @(negedge clk); alarm_clr = 0;
    check("R7 flag cleared", alarm_flag_o, 0);
    tick(); tick();
    alarm_clr = 1; tick_en = 1; @(negedge clk); alarm_clr = 0; tick_en = 0;
    check("R7 set beats clear", alarm_flag_o, 1);

    // R9 config writes leave count alone
    do_reset();
    for (int t = 0; t < 5; t++) tick();
    wr_alarm(32'd6);
    wr_mode(1'b1);
    check("R9 count kept", count_o, 5);
    tick();
    check("R9 count steps", count_o, 6);
    tick();
    check("R9 new alarm auto clear", {alarm_flag_o, count_o}, {1'b1, 32'd0});

    // R10 load beats tick, no event
    do_reset();
    wr_alarm(32'd0);
    time_we = 1; time_wdata = 32'd7; tick_en = 1;
    @(negedge clk); time_we = 0; tick_en = 0;
    check("R10 load wins", count_o, 7);
    check("R10 no alarm", {alarm_pulse_o, alarm_flag_o}, 0);
    time_we = 1; time_wdata = 32'd3; tick_en = 1;
    wr_alarm(32'd0);
    time_we = 0; tick_en = 0;
    wr_time(32'hFFFFFFFF);
    time_we = 1; time_wdata = 32'd0; tick_en = 1;
    @(negedge clk); time_we = 0; tick_en = 0;
    check("R10 no overflow", {ovf_flag_o, ovf_count_o}, 0);

    // R11 coherent snapshot across a wrap, R8 flag clear
    do_reset();
    wr_time(32'hFFFFFFFF);
    rd_req = 1; tick_en = 1; @(negedge clk); rd_req = 0; tick_en = 0;
    check("R11 pair before wrap", {rd_hi_o, rd_lo_o}, {16'd0, 32'hFFFFFFFF});
    check("R8 wrap live", {ovf_flag_o, ovf_count_o, count_o}, {1'b1, 16'd1, 32'd0});
    tick(); tick();
    check("R11 snapshot held", {rd_hi_o, rd_lo_o}, {16'd0, 32'hFFFFFFFF});
    ovf_clr = 1; @(negedge clk); ovf_clr = 0;
    check("R8 flag cleared", {ovf_flag_o, ovf_count_o}, {1'b0, 16'd1});
    rd_req = 1; @(negedge clk); rd_req = 0;
    check("R11 pair after wrap", {rd_hi_o, rd_lo_o}, {16'd1, 32'd2});

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule